// File: doc/BRIEF.md
# MSI Termination and Aggregation Unit

This unit is the landing point for message-signalled interrupt writes. Each posted write names one of 2048 vectors. The address offset picks a group and one of that group's index registers, and the data value picks a bit inside that register. The write sets that pending bit. The vectors are arranged as 16 groups, each with 8 index registers of 16 bits.

Software services an interrupt in two reads. It first reads the group's summary register to learn which index registers hold work. It then reads those index registers, and each such read hands back the pending bits and clears them in the same access. Every group drives one registered level interrupt line. The line stays high while any index register in that group holds a pending bit.

Top module: `msi_term_unit`

## Requirements
- R1: A write to offset `{1'b0, 7'(8*g + r), 16'h0000}` with a data value `d` below 16 sets bit `d` of index register `r` in group `g`. A later read of the same offset returns that bit in `rd_data[15:0]`, and the upper bits read as zero.
- R2: A write whose data value is 16 or more changes no pending bit.
- R3: A write to an offset whose low 16 bits are not all zero changes no pending bit.
- R4: A read of an index register returns its pending bits and leaves the register empty. A second read of the same register returns zero.
- R5: A read and a set that hit the same index register in the same cycle interact as follows. The read returns the bits that were pending before the write. The newly written bit stays pending afterwards.
- R6: A read at offset `{1'b1, 3'b000, 4'(g), 16'h0000}` returns, in bits [7:0], bit `r` high exactly when index register `r` of group `g` holds a pending bit. Bits [31:8] read as zero. The read clears nothing.
- R7: A write to a summary offset changes no state.
- R8: `irq_o[g]` is high while group `g` holds any pending bit. It follows a change of the pending state one clock later.
- R9: A synchronous reset clears every pending bit, drives `irq_o` low and drives `rd_valid` low.
- R10: `rd_data` and `rd_valid` appear one clock after `rd_en`. A read of an unmapped offset returns zero with `rd_valid` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Posted write strobe |
| wr_addr | input | 24 | Write offset |
| wr_data | input | 32 | Write data; selects the bit position |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 24 | Read offset |
| rd_data | output | 32 | Read data, registered |
| rd_valid | output | 1 | High one clock after `rd_en` |
| irq_o | output | 16 | One level interrupt per group, registered |

## Verification
Two things can land on the same index register in the same clock: an incoming vector write and the clear that a read of that register performs. The bench first leaves one bit pending. It then drives `rd_en` and `wr_en` together in a single cycle, both aimed at that register, with the write carrying a different bit. The verdict comes from two reads. The combined cycle must return only the old bit. A follow-up read must return only the new bit, which shows it survived the clear.

// File: rtl/msi_term_pkg.sv
package msi_term_pkg;
  // Default geometry shared by the unit, its sub-blocks and the checker
  localparam int unsigned DEF_NUM_GRP     = 16;
  localparam int unsigned DEF_IDX_PER_GRP = 8;
  localparam int unsigned DEF_IDX_BITS    = 16;
  localparam int unsigned DEF_ADDR_W      = 24;
  localparam int unsigned DEF_DATA_W      = 32;
  localparam int unsigned DEF_OFS_SHIFT   = 16;
endpackage

// File: rtl/msi_addr_decode.sv
// Address decode. Bit ADDR_W-1 selects the summary region (1) or the index region (0).
// Field [ADDR_W-2:OFS_SHIFT] is the register number; the bits below it must be zero.
// Group and register counts are assumed to be powers of two.
module msi_addr_decode #(
  parameter int unsigned NUM_GRP     = msi_term_pkg::DEF_NUM_GRP,
  parameter int unsigned IDX_PER_GRP = msi_term_pkg::DEF_IDX_PER_GRP,
  parameter int unsigned IDX_BITS    = msi_term_pkg::DEF_IDX_BITS,
  parameter int unsigned ADDR_W      = msi_term_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W      = msi_term_pkg::DEF_DATA_W,
  parameter int unsigned OFS_SHIFT   = msi_term_pkg::DEF_OFS_SHIFT,
  localparam int unsigned ROWS  = NUM_GRP * IDX_PER_GRP,
  localparam int unsigned ROW_W = $clog2(ROWS),
  localparam int unsigned GRP_W = $clog2(NUM_GRP),
  localparam int unsigned BIT_W = $clog2(IDX_BITS)
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              wr_hit,
  output logic [ROW_W-1:0]  wr_row,
  output logic [BIT_W-1:0]  wr_bit,
  output logic              rd_idx_hit,
  output logic              rd_sum_hit,
  output logic [ROW_W-1:0]  rd_row,
  output logic [GRP_W-1:0]  rd_grp
);
  localparam int unsigned FLD_W = ADDR_W - 1 - OFS_SHIFT;

  logic [FLD_W-1:0] wr_fld, rd_fld;
  logic wr_row_ok, rd_row_ok, rd_grp_ok;

  assign wr_fld = wr_addr[ADDR_W-2:OFS_SHIFT];
  assign rd_fld = rd_addr[ADDR_W-2:OFS_SHIFT];

  if (FLD_W > ROW_W) begin : g_row_hi
    assign wr_row_ok = (wr_fld[FLD_W-1:ROW_W] == '0);
    assign rd_row_ok = (rd_fld[FLD_W-1:ROW_W] == '0);
  end else begin : g_row_full
    assign wr_row_ok = 1'b1;
    assign rd_row_ok = 1'b1;
  end

  if (FLD_W > GRP_W) begin : g_grp_hi
    assign rd_grp_ok = (rd_fld[FLD_W-1:GRP_W] == '0);
  end else begin : g_grp_full
    assign rd_grp_ok = 1'b1;
  end

  assign wr_row = wr_fld[ROW_W-1:0];
  assign wr_bit = wr_data[BIT_W-1:0];
  assign wr_hit = wr_en && !wr_addr[ADDR_W-1] && wr_row_ok
                  && (wr_addr[OFS_SHIFT-1:0] == '0)
                  && (wr_data[DATA_W-1:BIT_W] == '0);

  assign rd_row     = rd_fld[ROW_W-1:0];
  assign rd_grp     = rd_fld[GRP_W-1:0];
  assign rd_idx_hit = !rd_addr[ADDR_W-1] && rd_row_ok && (rd_addr[OFS_SHIFT-1:0] == '0);
  assign rd_sum_hit = rd_addr[ADDR_W-1] && rd_grp_ok && (rd_addr[OFS_SHIFT-1:0] == '0);
endmodule

// File: rtl/msi_pend_array.sv
// Pending-bit matrix. In one row a set is applied after a clear, so a new bit wins over the clear.
module msi_pend_array #(
  parameter int unsigned NUM_GRP     = msi_term_pkg::DEF_NUM_GRP,
  parameter int unsigned IDX_PER_GRP = msi_term_pkg::DEF_IDX_PER_GRP,
  parameter int unsigned IDX_BITS    = msi_term_pkg::DEF_IDX_BITS,
  localparam int unsigned ROWS  = NUM_GRP * IDX_PER_GRP,
  localparam int unsigned ROW_W = $clog2(ROWS),
  localparam int unsigned BIT_W = $clog2(IDX_BITS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     set_en,
  input  logic [ROW_W-1:0]         set_row,
  input  logic [BIT_W-1:0]         set_bit,
  input  logic                     clr_en,
  input  logic [ROW_W-1:0]         clr_row,
  output logic [ROWS*IDX_BITS-1:0] pend_flat,
  output logic [ROWS-1:0]          row_any
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [IDX_BITS-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else begin
        if (clr_en && clr_row == ROW_W'(r)) q <= '0;
        if (set_en && set_row == ROW_W'(r)) q[set_bit] <= 1'b1;
      end
    end
    assign pend_flat[r*IDX_BITS +: IDX_BITS] = q;
    assign row_any[r] = |q;
  end
endmodule

// File: rtl/msi_irq_aggr.sv
// Per-group OR of the row flags, and the registered interrupt lines.
module msi_irq_aggr #(
  parameter int unsigned NUM_GRP     = msi_term_pkg::DEF_NUM_GRP,
  parameter int unsigned IDX_PER_GRP = msi_term_pkg::DEF_IDX_PER_GRP
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_GRP*IDX_PER_GRP-1:0] row_any,
  output logic [NUM_GRP-1:0]             grp_any,
  output logic [NUM_GRP-1:0]             irq_o
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    assign grp_any[g] = |row_any[g*IDX_PER_GRP +: IDX_PER_GRP];
  end

  always_ff @(posedge clk) begin
    if (rst) irq_o <= '0;
    else     irq_o <= grp_any;
  end
endmodule

// File: rtl/msi_term_unit.sv
module msi_term_unit #(
  parameter int unsigned NUM_GRP     = msi_term_pkg::DEF_NUM_GRP,
  parameter int unsigned IDX_PER_GRP = msi_term_pkg::DEF_IDX_PER_GRP,
  parameter int unsigned IDX_BITS    = msi_term_pkg::DEF_IDX_BITS,
  parameter int unsigned ADDR_W      = msi_term_pkg::DEF_ADDR_W,
  parameter int unsigned DATA_W      = msi_term_pkg::DEF_DATA_W,
  parameter int unsigned OFS_SHIFT   = msi_term_pkg::DEF_OFS_SHIFT
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic               rd_valid,
  output logic [NUM_GRP-1:0] irq_o
);
  localparam int unsigned ROWS  = NUM_GRP * IDX_PER_GRP;
  localparam int unsigned ROW_W = $clog2(ROWS);
  localparam int unsigned GRP_W = $clog2(NUM_GRP);
  localparam int unsigned BIT_W = $clog2(IDX_BITS);

  logic                     wr_hit, rd_idx_hit, rd_sum_hit, clr_en;
  logic [ROW_W-1:0]         wr_row, rd_row;
  logic [BIT_W-1:0]         wr_bit;
  logic [GRP_W-1:0]         rd_grp;
  logic [ROWS*IDX_BITS-1:0] pend_flat;
  logic [ROWS-1:0]          row_any;
  logic [NUM_GRP-1:0]       grp_any;
  logic [IDX_BITS-1:0]      row_val;
  logic [IDX_PER_GRP-1:0]   sum_val;

  msi_addr_decode #(
    .NUM_GRP(NUM_GRP), .IDX_PER_GRP(IDX_PER_GRP), .IDX_BITS(IDX_BITS),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_SHIFT(OFS_SHIFT)
  ) u_dec (
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .wr_hit(wr_hit), .wr_row(wr_row), .wr_bit(wr_bit),
    .rd_idx_hit(rd_idx_hit), .rd_sum_hit(rd_sum_hit), .rd_row(rd_row), .rd_grp(rd_grp)
  );

  // Only a read of the index region clears anything
  assign clr_en = rd_en && rd_idx_hit;

  msi_pend_array #(
    .NUM_GRP(NUM_GRP), .IDX_PER_GRP(IDX_PER_GRP), .IDX_BITS(IDX_BITS)
  ) u_pend (
    .clk(clk), .rst(rst),
    .set_en(wr_hit), .set_row(wr_row), .set_bit(wr_bit),
    .clr_en(clr_en), .clr_row(rd_row),
    .pend_flat(pend_flat), .row_any(row_any)
  );

  msi_irq_aggr #(
    .NUM_GRP(NUM_GRP), .IDX_PER_GRP(IDX_PER_GRP)
  ) u_aggr (
    .clk(clk), .rst(rst), .row_any(row_any), .grp_any(grp_any), .irq_o(irq_o)
  );

  assign row_val = pend_flat[rd_row*IDX_BITS +: IDX_BITS];
  assign sum_val = row_any[rd_grp*IDX_PER_GRP +: IDX_PER_GRP];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      rd_data  <= '0;
      if (rd_en && rd_idx_hit)      rd_data <= DATA_W'(row_val);
      else if (rd_en && rd_sum_hit) rd_data <= DATA_W'(sum_val);
    end
  end
endmodule

// File: rtl/msi_term_chk.sv
module msi_term_chk #(
  parameter int unsigned NUM_GRP     = msi_term_pkg::DEF_NUM_GRP,
  parameter int unsigned IDX_PER_GRP = msi_term_pkg::DEF_IDX_PER_GRP,
  parameter int unsigned IDX_BITS    = msi_term_pkg::DEF_IDX_BITS,
  localparam int unsigned ROWS  = NUM_GRP * IDX_PER_GRP,
  localparam int unsigned ROW_W = $clog2(ROWS),
  localparam int unsigned BIT_W = $clog2(IDX_BITS)
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     wr_en,
  input logic                     wr_hit,
  input logic [ROW_W-1:0]         wr_row,
  input logic [BIT_W-1:0]         wr_bit,
  input logic                     rd_en,
  input logic                     rd_sum_hit,
  input logic                     clr_en,
  input logic [ROW_W-1:0]         rd_row,
  input logic [ROWS*IDX_BITS-1:0] pend_flat,
  input logic [NUM_GRP-1:0]       grp_any,
  input logic [NUM_GRP-1:0]       irq_o
);
  logic                   set_q, clr_q;
  logic [ROW_W+BIT_W-1:0] set_idx_q;
  logic [ROW_W-1:0]       clr_row_q;
  logic [IDX_BITS-1:0]    clr_exp_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      set_q <= 1'b0; clr_q <= 1'b0;
      set_idx_q <= '0; clr_row_q <= '0; clr_exp_q <= '0;
    end else begin
      set_q     <= wr_hit;
      set_idx_q <= {wr_row, wr_bit};
      clr_q     <= clr_en;
      clr_row_q <= rd_row;
      clr_exp_q <= (wr_hit && wr_row == rd_row) ? (IDX_BITS'(1) << wr_bit) : '0;
    end
  end

  // R1
  set_bit_chk: assert property (@(posedge clk) disable iff (rst)
    set_q |-> pend_flat[set_idx_q]);

  // R4
  clear_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    clr_q |-> pend_flat[clr_row_q*IDX_BITS +: IDX_BITS] == clr_exp_q);

  // R3
  bad_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_hit && !clr_en) |=> $stable(pend_flat));

  // R6
  summary_no_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_sum_hit && !wr_hit) |=> $stable(pend_flat));

  // R8
  irq_follows_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == $past(grp_any));
endmodule

bind msi_term_unit msi_term_chk #(
  .NUM_GRP(NUM_GRP), .IDX_PER_GRP(IDX_PER_GRP), .IDX_BITS(IDX_BITS)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_hit(wr_hit), .wr_row(wr_row), .wr_bit(wr_bit),
  .rd_en(rd_en), .rd_sum_hit(rd_sum_hit), .clr_en(clr_en), .rd_row(rd_row),
  .pend_flat(pend_flat), .grp_any(grp_any), .irq_o(irq_o)
);

// File: tb/msi_term_unit_bench.sv
`timescale 1ns/1ps
module msi_term_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [23:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic [15:0] irq_o;

  int errors = 0, checks = 0;
  logic [15:0] mdl [128];

  always #4 clk = ~clk;

  msi_term_unit u_msi_term_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid), .irq_o(irq_o)
  );

  function automatic logic [23:0] idx_a(int g, int r);
    return {1'b0, 7'(g*8 + r), 16'h0000};
  endfunction
  function automatic logic [23:0] sum_a(int g);
    return {1'b1, 3'b000, 4'(g), 16'h0000};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Bench-side model: computes read results and pending state from the requirements
  task automatic op(bit dw, logic [23:0] wa, logic [31:0] wd,
                    bit dr, logic [23:0] ra, output logic [31:0] exp_rd);
    int row;
    exp_rd = '0;
    if (dr && ra[15:0] == 16'h0) begin
      if (!ra[23]) begin
        row = int'(ra[22:16]);
        exp_rd = {16'h0, mdl[row]};
        mdl[row] = '0;
      end else if (ra[22:20] == 3'b000) begin
        for (int r = 0; r < 8; r++) exp_rd[r] = |mdl[int'(ra[19:16])*8 + r];
      end
    end
    if (dw && !wa[23] && wa[15:0] == 16'h0 && wd < 32'd16)
      mdl[int'(wa[22:16])][wd[3:0]] = 1'b1;
    @(negedge clk);
    wr_en = dw; wr_addr = wa; wr_data = wd; rd_en = dr; rd_addr = ra;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(logic [23:0] a, logic [31:0] d);
    logic [31:0] unused_rd;
    op(1'b1, a, d, 1'b0, '0, unused_rd);
  endtask

  task automatic rd_chk(string req, logic [23:0] a);
    logic [31:0] e;
    op(1'b0, '0, '0, 1'b1, a, e);
    chk(req, rd_data, e);
    chk(req, {31'h0, rd_valid}, 32'h1);
  endtask

  task automatic irq_chk(string req);
    logic [15:0] e;
    @(posedge clk); @(negedge clk);
    for (int g = 0; g < 16; g++) begin
      e[g] = 1'b0;
      for (int r = 0; r < 8; r++) e[g] |= |mdl[g*8 + r];
    end
    chk(req, {16'h0, irq_o}, {16'h0, e});
  endtask

  task automatic all_sum_chk(string req);
    for (int g = 0; g < 16; g++) rd_chk(req, sum_a(g));
  endtask

  task automatic t_reset;
    chk("R9 irq", {16'h0, irq_o}, 32'h0);
    chk("R9 rd_valid", {31'h0, rd_valid}, 32'h0);
    rd_chk("R9 summary", sum_a(0));
    rd_chk("R9 index", idx_a(15, 7));
  endtask

  task automatic t_basic;
    wr(idx_a(3, 5), 32'd9);
    irq_chk("R8 rise");
    rd_chk("R1 read", idx_a(3, 5));
    rd_chk("R4 reread", idx_a(3, 5));
    irq_chk("R8 fall");
  endtask

  task automatic t_multi;
    wr(idx_a(0, 0), 32'd0);
    wr(idx_a(15, 7), 32'd15);
    wr(idx_a(7, 2), 32'd4);
    wr(idx_a(7, 2), 32'd11);
    wr(idx_a(7, 6), 32'd1);
    irq_chk("R8 multi");
    rd_chk("R6 sum g7", sum_a(7));
    rd_chk("R6 sum g7 again", sum_a(7));
    rd_chk("R6 sum g15", sum_a(15));
    rd_chk("R1 two bits", idx_a(7, 2));
    rd_chk("R6 sum after clear", sum_a(7));
    rd_chk("R1 edge", idx_a(15, 7));
    rd_chk("R1 zero", idx_a(0, 0));
    rd_chk("R1 g7r6", idx_a(7, 6));
    irq_chk("R8 drained");
  endtask

  task automatic t_bad_data;
    wr(idx_a(4, 1), 32'd16);
    wr(idx_a(4, 1), 32'hFFFF_0003);
    irq_chk("R2 irq");
    all_sum_chk("R2 summary");
  endtask

  task automatic t_bad_addr;
    wr(idx_a(5, 3) | 24'h000001, 32'd2);
    wr(idx_a(5, 3) | 24'h008000, 32'd2);
    irq_chk("R3 irq");
    rd_chk("R3 index", idx_a(5, 3));
    wr(sum_a(5), 32'd2);
    wr(sum_a(9), 32'd0);
    irq_chk("R7 irq");
    all_sum_chk("R7 summary");
  endtask

  task automatic t_collide;
    logic [31:0] e;
    wr(idx_a(2, 3), 32'd1);
    op(1'b1, idx_a(2, 3), 32'd6, 1'b1, idx_a(2, 3), e);
    chk("R5 old bits", rd_data, e);
    chk("R5 old bits const", rd_data, 32'h0000_0002);
    irq_chk("R5 irq kept");
    rd_chk("R5 new bit", idx_a(2, 3));
  endtask

  task automatic t_unmapped;
    rd_chk("R10 odd offset", idx_a(1, 1) | 24'h000004);
    rd_chk("R10 high summary", 24'h900000);
    @(negedge clk);
    chk("R10 idle valid", {31'h0, rd_valid}, 32'h0);
    wr(idx_a(9, 0), 32'd3);
    rst = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 128; i++) mdl[i] = '0;
    chk("R9 irq after reset", {16'h0, irq_o}, 32'h0);
    rd_chk("R9 cleared", idx_a(9, 0));
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_multi();
    t_bad_data();
    t_bad_addr();
    t_collide();
    t_unmapped();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule